// File: doc/BRIEF.md
# One-Way Clock Source Switcher

This block hands the system clock over from an on-chip oscillator to an external clock when software asks for it, and the handover cannot be reversed except by reset. Software first waits for the external source to settle and then raises a request bit. The block confirms that the external clock is toggling by counting its rising edges. It then moves the output clock across without a runt pulse, reports completion on a status bit, and only after that withdraws the enable of the internal oscillator.

The selected source drives the fast bus clock output unchanged, and a toggle flop on that clock makes the half-rate bus clock. A 2-bit mode input describes the external option. Only the crystal code turns the second oscillator pin into a clock driver. After the switch nothing watches the external clock, so if it stops the output simply stops with it.

Top module: `clk_src_switch`

## Requirements
- R1: Reset, sampled low on a rising edge of the internal clock and of the external clock, clears `switched`, drives `int_osc_en` high and makes `busclk_x4` follow the internal clock.
- R2: While `go_req` has never been high since reset, `busclk_x4` keeps following the internal clock and `switched` stays 0, whatever the external clock does.
- R3: After `go_req` is set, the switch does not happen until at least two rising edges of the external clock have been seen. If the external clock is idle, the block stays on the internal clock with `switched` at 0.
- R4: No high or low pulse on `busclk_x4` is shorter than the shorter half period of the two input clocks, including across the handover. The two internal gate enables are never both open.
- R5: `switched` rises strictly before `int_osc_en` falls, and `int_osc_en` is low only while `switched` is 1.
- R6: Once `switched` is 1, `busclk_x4` equals the external clock.
- R7: The request is sticky. Once `switched` is 1, dropping `go_req` changes nothing: `switched` stays 1, `int_osc_en` stays 0 and the output stays on the external clock.
- R8: If the external clock stops after the switch, `busclk_x4` shows no further edges (no fallback to the internal clock) and `switched` stays 1.
- R9: `busclk_x2` toggles on every rising edge of `busclk_x4`, so it has half as many rising edges.
- R10: `xtal_pin_en` is 1 only for `mode_sel` = 2'b11 (crystal). It is 0 for 2'b00, 2'b01 and 2'b10.
- R11: A reset after a completed switch returns the block to its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal oscillator clock |
| ext_clk | input | 1 | External clock source |
| rst_n | input | 1 | Synchronous active-low reset |
| go_req | input | 1 | Software request to move to the external clock (sticky once seen) |
| mode_sel | input | 2 | External option code; 2'b11 = crystal |
| busclk_x4 | output | 1 | Selected source clock |
| busclk_x2 | output | 1 | Selected source divided by two |
| switched | output | 1 | Handover complete |
| int_osc_en | output | 1 | Enable for the internal oscillator |
| xtal_pin_en | output | 1 | Second oscillator pin drives a clock |

## Verification
The bench requests the switch while the external clock is idle, and then after a single edge. A design that skipped the activity check would move to a dead clock and freeze the system. A pulse-width monitor runs across the handover to catch a mux that changes gates at the wrong phase and leaves a sliver pulse. The bench checks the time order of status and oscillator disable, because reversing them would report a switch after the old clock was already gone. It also drops the request and halts the external clock after the switch. A design that reverted would then show internal-clock edges again or clear the status bit.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the clock source switcher.
// Assumes: mode codes are fixed by the software view of the block.
package clksw_pkg;
    typedef enum logic [1:0] {
        SRC_INTERNAL = 2'b00,
        SRC_EXT_CLK  = 2'b01,
        SRC_EXT_RC   = 2'b10,
        SRC_CRYSTAL  = 2'b11
    } src_mode_e;
endpackage

// File: rtl/clksw_detect.sv
`timescale 1ns/1ps
// Activity detector in the external clock domain.
// Brings the request across with a synchronizer. Once the synchronized request
// is seen, counts rising edges of the external clock. After EDGE_COUNT edges it
// raises a sticky go-ahead.
// Assumes: the external clock runs while reset is low, so the reset is seen.
module clksw_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_COUNT  = 2
) (
    input  logic ext_clk,
    input  logic rst_n,
    input  logic req_async,
    output logic ext_ok
);
    localparam int CW = $clog2(EDGE_COUNT + 1);

    logic [SYNC_STAGES-1:0] req_sync;
    logic [CW-1:0]          edge_cnt;
    logic                   req_seen;

    assign req_seen = req_sync[SYNC_STAGES-1];

    // Synchronize the request into the external domain.
    always_ff @(posedge ext_clk) begin
        if (!rst_n) req_sync <= '0;
        else        req_sync <= {req_sync[SYNC_STAGES-2:0], req_async};
    end

    // Count external edges after the request and latch the go-ahead.
    always_ff @(posedge ext_clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            ext_ok   <= 1'b0;
        end else if (req_seen && !ext_ok) begin
            edge_cnt <= edge_cnt + 1'b1;
            if (edge_cnt == CW'(EDGE_COUNT - 1)) ext_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/clksw_gate.sv
`timescale 1ns/1ps
// One side of a glitch-free clock mux.
// The enable request passes a synchronizer on the rising edge. It is then
// retimed on the falling edge, so the gate only changes while its own clock is low.
// Assumes: the opposite side's gate comes from an equal cell (mutual exclusion).
module clksw_gate #(
    parameter int   SYNC_STAGES = 2,
    parameter logic RST_OPEN    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic other_gate,
    output logic gate
);
    logic [SYNC_STAGES-1:0] chain;

    // Synchronize "want and the other side is shut" on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {SYNC_STAGES{RST_OPEN}};
        else        chain <= {chain[SYNC_STAGES-2:0], want & ~other_gate};
    end

    // Open or close the gate only while the clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) gate <= RST_OPEN;
        else        gate <= chain[SYNC_STAGES-1];
    end
endmodule

// File: rtl/clksw_div.sv
`timescale 1ns/1ps
// Divide-by-two of the selected clock.
// Assumes: the selected clock toggles during reset, so the flop clears.
module clksw_div (
    input  logic clk_in,
    input  logic rst_n,
    output logic clk_half
);
    // Toggle on every rising edge of the selected clock.
    always_ff @(posedge clk_in) begin
        if (!rst_n) clk_half <= 1'b0;
        else        clk_half <= ~clk_half;
    end
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
// One-way switch from the internal oscillator to an external clock.
// Order of events: sticky request, then the external activity check, then the
// gate handover. Status rises next, and one external cycle later the internal
// oscillator enable drops. Only reset undoes this. There is no clock monitor.
// Assumes: both clocks run while reset is low.
module clk_src_switch #(
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_COUNT  = 2
) (
    input  logic       int_clk,
    input  logic       ext_clk,
    input  logic       rst_n,
    input  logic       go_req,
    input  logic [1:0] mode_sel,
    output logic       busclk_x4,
    output logic       busclk_x2,
    output logic       switched,
    output logic       int_osc_en,
    output logic       xtal_pin_en
);
    import clksw_pkg::*;

    logic go_q;
    logic want_ext;
    logic int_gate;
    logic ext_gate;
    logic osc_off;

    // Hold the software request until reset.
    always_ff @(posedge int_clk) begin
        if (!rst_n)      go_q <= 1'b0;
        else if (go_req) go_q <= 1'b1;
    end

    clksw_detect #(.SYNC_STAGES(SYNC_STAGES), .EDGE_COUNT(EDGE_COUNT)) u_detect (
        .ext_clk  (ext_clk),
        .rst_n    (rst_n),
        .req_async(go_q),
        .ext_ok   (want_ext)
    );

    clksw_gate #(.SYNC_STAGES(SYNC_STAGES), .RST_OPEN(1'b1)) u_gate_int (
        .clk       (int_clk),
        .rst_n     (rst_n),
        .want      (~want_ext),
        .other_gate(ext_gate),
        .gate      (int_gate)
    );

    clksw_gate #(.SYNC_STAGES(SYNC_STAGES), .RST_OPEN(1'b0)) u_gate_ext (
        .clk       (ext_clk),
        .rst_n     (rst_n),
        .want      (want_ext),
        .other_gate(int_gate),
        .gate      (ext_gate)
    );

    assign busclk_x4 = (int_clk & int_gate) | (ext_clk & ext_gate);

    clksw_div u_div (
        .clk_in  (busclk_x4),
        .rst_n   (rst_n),
        .clk_half(busclk_x2)
    );

    // Status first, oscillator shut-off one external cycle later.
    always_ff @(posedge ext_clk) begin
        if (!rst_n) begin
            switched <= 1'b0;
            osc_off  <= 1'b0;
        end else begin
            if (ext_gate) switched <= 1'b1;
            if (switched) osc_off  <= 1'b1;
        end
    end

    assign int_osc_en  = ~osc_off;
    assign xtal_pin_en = (src_mode_e'(mode_sel) == SRC_CRYSTAL);

    // R4
    gates_exclusive_chk: assert property (@(posedge int_clk) disable iff (!rst_n)
        !(int_gate && ext_gate));
    // R7
    status_sticky_chk: assert property (@(posedge ext_clk) disable iff (!rst_n)
        switched |=> switched);
    // R5
    osc_off_after_status_chk: assert property (@(posedge ext_clk) disable iff (!rst_n)
        $fell(int_osc_en) |-> $past(switched));
    // R5
    osc_off_needs_status_chk: assert property (@(posedge ext_clk) disable iff (!rst_n)
        !int_osc_en |-> switched);
    // R2
    no_request_no_switch_chk: assert property (@(posedge int_clk) disable iff (!rst_n)
        !go_q |-> (int_osc_en && !ext_gate));
endmodule

// File: tb/tb_clk_src_switch.sv
`timescale 1ns/1ps
module tb_clk_src_switch;
    localparam int  CLK_PERIOD = 10;
    localparam int  EXT_HALF   = 7;
    localparam real MIN_PULSE  = 4.9;

    logic int_clk = 1'b0, ext_clk = 1'b0, rst_n = 1'b0, go_req = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic busclk_x4, busclk_x2, switched, int_osc_en, xtal_pin_en;
    logic ext_run = 1'b1;

    clk_src_switch dut (.*);

    always #(CLK_PERIOD/2) int_clk = ~int_clk;
    initial forever begin
        #(EXT_HALF);
        if (ext_run) ext_clk = ~ext_clk;
    end

    typedef struct { string req; logic [31:0] exp; } item_t;
    item_t exp_q[$];
    logic [31:0] act_v;
    event obs_ev;
    int checks = 0, fails = 0;
    bit done = 0;

    // Monitor: pops expected items and compares with observed values.
    initial forever begin
        item_t it;
        @(obs_ev);
        it = exp_q.pop_front();
        checks++;
        if (act_v !== it.exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", it.req, act_v, it.exp);
        end
    end

    // Driver side: push the expectation, then hand over the observation.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        exp_q.push_back('{req, exp});
        act_v = act;
        -> obs_ev;
        #1;
    endtask

    // Pulse-width monitor and edge counters on the outputs.
    bit pw_on = 0;
    int pw_bad = 0, x4_rises = 0, x2_rises = 0;
    realtime last_edge = -1.0, t_stat = 0.0, t_off = 0.0;
    always @(busclk_x4) begin
        if (pw_on && last_edge >= 0.0 && ($realtime - last_edge) < MIN_PULSE) pw_bad++;
        last_edge = $realtime;
    end
    always @(posedge busclk_x4) x4_rises++;
    always @(posedge busclk_x2) x2_rises++;
    always @(posedge switched) t_stat = $realtime;
    always @(negedge int_osc_en) t_off = $realtime;

    task automatic follows_int(input string req);
        logic a, b;
        @(posedge int_clk); #2 a = busclk_x4;
        @(negedge int_clk); #2 b = busclk_x4;
        check(req, {30'd0, a, b}, 32'd2);
    endtask

    task automatic follows_ext(input string req);
        logic a, b;
        @(posedge ext_clk); #2 a = busclk_x4;
        @(negedge ext_clk); #2 b = busclk_x4;
        check(req, {30'd0, a, b}, 32'd2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n4, n2;
        repeat (10) @(posedge int_clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        check("R1 switched", switched, 0);
        check("R1 int_osc_en", int_osc_en, 1);
        follows_int("R1 output on internal clock");
        // R2 no request, external running
        repeat (40) @(posedge int_clk);
        #2 check("R2 switched", switched, 0);
        follows_int("R2 output on internal clock");
        // R10 crystal pin enable per mode code
        for (int m = 0; m < 4; m++) begin
            mode_sel = m[1:0]; #1;
            check($sformatf("R10 xtal_pin_en mode %0d", m), xtal_pin_en, (m == 3) ? 1 : 0);
        end
        // R3 request with idle external clock
        @(negedge ext_clk); ext_run = 1'b0;
        @(negedge int_clk); go_req = 1'b1;
        repeat (40) @(posedge int_clk);
        #2 check("R3 idle ext switched", switched, 0);
        check("R3 idle ext int_osc_en", int_osc_en, 1);
        follows_int("R3 idle ext output on internal");
        #3 ext_clk = 1'b1; #(EXT_HALF) ext_clk = 1'b0;
        repeat (5) @(posedge int_clk);
        #2 check("R3 one edge switched", switched, 0);
        // R4/R5/R6 handover
        pw_on = 1;
        ext_run = 1'b1;
        for (int i = 0; i < 300 && !switched; i++) @(posedge int_clk);
        repeat (10) @(posedge ext_clk);
        #2 check("R5 switched set", switched, 1);
        check("R5 int_osc_en cleared", int_osc_en, 0);
        check("R5 status before disable", (t_stat > 0.0 && t_stat < t_off) ? 1 : 0, 1);
        follows_ext("R6 output on external clock");
        // R9 divider
        n4 = x4_rises; n2 = x2_rises;
        repeat (20) @(posedge ext_clk);
        #2 n4 = x4_rises - n4; n2 = x2_rises - n2;
        check("R9 half rate", (n2 == n4 / 2 || n2 == (n4 + 1) / 2) ? 1 : 0, 1);
        // R7 drop request
        go_req = 1'b0;
        repeat (20) @(posedge int_clk);
        #2 check("R7 switched after drop", switched, 1);
        check("R7 int_osc_en after drop", int_osc_en, 0);
        follows_ext("R7 output stays external");
        // R8 external clock stops
        @(negedge ext_clk); ext_run = 1'b0;
        #3 n4 = x4_rises;
        repeat (30) @(posedge int_clk);
        #2 check("R8 no edges after stop", x4_rises - n4, 0);
        check("R8 switched held", switched, 1);
        check("R4 pulse widths", pw_bad, 0);
        pw_on = 0;
        // R11 reset after switch
        ext_run = 1'b1;
        @(negedge int_clk); rst_n = 1'b0;
        repeat (10) @(posedge int_clk);
        #2 rst_n = 1'b1;
        repeat (4) @(posedge int_clk);
        #2 check("R11 switched", switched, 0);
        check("R11 int_osc_en", int_osc_en, 1);
        follows_int("R11 output on internal clock");
        done = 1;
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule